// File: doc/BRIEF.md
# Stop-Mode Oscillator Request Gater

While the chip sits in a stop mode, every clock in the core domain is halted and the fast internal oscillator is off. A few communication peripherals that can wake the chip still need a clock to take in an incoming frame. This block lets each of them request the oscillator on its own. The block switches the oscillator on. Once the oscillator reports that it is stable, the block opens a clock gate toward that requester only. When the frame ends, the block does one of two things. If the frame does not qualify as a wakeup, it closes the gate and drops the oscillator again, so the chip stays in stop mode. If the frame is a wakeup frame, it raises a system wake request and keeps the oscillator running.

The block serves four requesters: two inter-IC serial ports, one UART-style port and one low-power UART. Each requester runs its own channel state machine, and the oscillator enable is the OR of every channel that needs it. The oscillator-ready input comes from the analog domain and passes through a synchronizer before it can open a gate. Outside stop mode the block does not act on requests, and each gate simply follows its run-mode enable.

Top module: `osc_req_gater`

## Requirements
- R1: While reset is high and in the first cycle after it, with `stop_mode` = 1, `osc_en`, `wake_req` and all bits of `gate_en` read 0.
- R2: In stop mode, a request bit `req[i]` sampled high on a clock edge drives `osc_en` to 1 from that edge on. The request is latched, so dropping `req[i]` afterwards does not cancel it.
- R3: A requester's gate opens on the first edge after the synchronized ready is high. `osc_ready` passes through `SYNC_STAGES` flops, so the gate opens SYNC_STAGES+1 edges after `osc_ready` rises. It never opens earlier.
- R4: Only the gate bit `gate_en[i]` of a requester whose request is being served opens. All other gate bits stay 0.
- R5: A `frame_done[i]` pulse with `wake_match[i]` = 0 while gate i is open closes gate i at the next edge. `osc_en` drops at that same edge if no other channel is active, and `wake_req` stays 0. If `req[i]` is still high at that edge, the channel goes back to waiting for ready instead.
- R6: A `frame_done[i]` pulse with `wake_match[i]` = 1 while gate i is open raises `wake_req` at the next edge. `osc_en` and gate i then stay at 1 for as long as `stop_mode` stays high.
- R7: With several channels active, each has its own gate. `osc_en` stays 1 until the last active channel has finished its frame.
- R8: While `stop_mode` = 0, `gate_en` equals `run_en`, and `osc_en` and `wake_req` are 0, whatever the state of `req`, `frame_done` and `wake_match`.
- R9: A clock edge with `stop_mode` = 0 returns every channel to idle. On re-entry into stop mode, `osc_en` and `wake_req` are 0 and no gate is open.
- R10: A `frame_done[i]` pulse while channel i still waits for ready is ignored. The channel keeps `osc_en` high, keeps its gate closed, and opens the gate once ready arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock that keeps running in stop mode |
| rst | input | 1 | Synchronous active-high reset |
| stop_mode | input | 1 | High while the chip is in stop mode |
| req | input | NUM_REQ | Per-requester oscillator request |
| frame_done | input | NUM_REQ | Per-requester one-cycle end-of-frame pulse |
| wake_match | input | NUM_REQ | Per-requester flag, valid with frame_done: the frame is a wakeup frame |
| run_en | input | NUM_REQ | Run-mode clock enables, passed to the gates outside stop mode |
| osc_ready | input | 1 | Asynchronous oscillator-stable flag |
| osc_en | output | 1 | Oscillator enable |
| gate_en | output | NUM_REQ | Per-requester clock-gate enable |
| wake_req | output | 1 | System wake request |

## Verification
The main function is exercised with four patterns. The first is a single requester whose frame is not a wakeup. It separates per-channel gating from a global gate and shows the oscillator dropping afterwards. The second is a single requester with a wakeup frame, which shows that the wake request and the oscillator hold. The third is two requesters served at once and finishing at different times, which shows that the oscillator is released only by the last one. The fourth is a frame-end pulse arriving before ready, which shows that the channel ignores it. The gate-opening cycle is counted from the ready edge through the synchronizer, so an early or late gate is caught. Run-mode passthrough and clearing on stop-mode exit are checked with requests held high.

// File: rtl/oscg_pkg.sv
package oscg_pkg;

    typedef enum logic [1:0] {
        CH_IDLE     = 2'd0,
        CH_WAIT_RDY = 2'd1,
        CH_RECV     = 2'd2,
        CH_WAKE     = 2'd3
    } ch_state_e;

    typedef struct packed {
        logic need_osc;
        logic gate_open;
        logic wake;
    } ch_out_t;

    function automatic ch_out_t ch_decode(ch_state_e s);
        ch_out_t o;
        o.need_osc  = (s != CH_IDLE);
        o.gate_open = (s == CH_RECV) || (s == CH_WAKE);
        o.wake      = (s == CH_WAKE);
        return o;
    endfunction

endpackage

// File: rtl/oscg_ready_sync.sv
module oscg_ready_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= d_async;
            for (int k = 1; k < STAGES; k++) begin
                chain[k] <= chain[k-1];
            end
        end
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/oscg_channel.sv
module oscg_channel
    import oscg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    stop_mode,
    input  logic    req,
    input  logic    rdy,
    input  logic    frame_done,
    input  logic    wake_match,
    output ch_out_t ch_out
);
    ch_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        if (!stop_mode) begin
            state_nx = CH_IDLE;
        end else begin
            unique case (state)
                CH_IDLE:     if (req) state_nx = CH_WAIT_RDY;
                CH_WAIT_RDY: if (rdy) state_nx = CH_RECV;
                CH_RECV: begin
                    if (frame_done) begin
                        if (wake_match) state_nx = CH_WAKE;
                        else if (req)   state_nx = CH_WAIT_RDY;
                        else            state_nx = CH_IDLE;
                    end
                end
                CH_WAKE:     state_nx = CH_WAKE;
                default:     state_nx = CH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= CH_IDLE;
        else     state <= state_nx;
    end

    assign ch_out = ch_decode(state);
endmodule

// File: rtl/osc_req_gater.sv
module osc_req_gater
    import oscg_pkg::*;
#(
    parameter int NUM_REQ     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stop_mode,
    input  logic [NUM_REQ-1:0] req,
    input  logic [NUM_REQ-1:0] frame_done,
    input  logic [NUM_REQ-1:0] wake_match,
    input  logic [NUM_REQ-1:0] run_en,
    input  logic               osc_ready,
    output logic               osc_en,
    output logic [NUM_REQ-1:0] gate_en,
    output logic               wake_req
);
    logic    rdy_sync;
    ch_out_t ch_out [NUM_REQ];

    oscg_ready_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (osc_ready),
        .q_sync  (rdy_sync)
    );

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_ch
        oscg_channel u_ch (
            .clk        (clk),
            .rst        (rst),
            .stop_mode  (stop_mode),
            .req        (req[g]),
            .rdy        (rdy_sync),
            .frame_done (frame_done[g]),
            .wake_match (wake_match[g]),
            .ch_out     (ch_out[g])
        );
    end

    always_comb begin
        logic any_osc;
        logic any_wake;
        any_osc  = 1'b0;
        any_wake = 1'b0;
        for (int k = 0; k < NUM_REQ; k++) begin
            any_osc  = any_osc  | ch_out[k].need_osc;
            any_wake = any_wake | ch_out[k].wake;
            gate_en[k] = stop_mode ? ch_out[k].gate_open : run_en[k];
        end
        osc_en   = stop_mode & any_osc;
        wake_req = stop_mode & any_wake;
    end
endmodule

// File: rtl/osc_req_gater_chk.sv
module osc_req_gater_chk #(
    parameter int NUM_REQ = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               stop_mode,
    input logic [NUM_REQ-1:0] req,
    input logic [NUM_REQ-1:0] run_en,
    input logic               rdy_sync,
    input logic               osc_en,
    input logic [NUM_REQ-1:0] gate_en,
    input logic               wake_req
);
    AST_GATE_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
        (stop_mode && $past(stop_mode) && !$past(rst) && ((gate_en & ~$past(gate_en)) != '0))
        |-> $past(rdy_sync)); // R3

    AST_GATE_NEEDS_OSC: assert property (@(posedge clk) disable iff (rst)
        (stop_mode && (gate_en != '0)) |-> osc_en); // R7

    AST_RUN_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
        !stop_mode |-> (gate_en == run_en) && !osc_en && !wake_req); // R8

    AST_WAKE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (stop_mode && $past(stop_mode) && !$past(rst) && $past(wake_req))
        |-> wake_req && osc_en); // R6

    AST_REQ_OSC: assert property (@(posedge clk) disable iff (rst)
        (stop_mode && $past(stop_mode) && !$past(rst) && ($past(req) != '0))
        |-> osc_en); // R2
endmodule

bind osc_req_gater osc_req_gater_chk #(.NUM_REQ(NUM_REQ)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .stop_mode (stop_mode),
    .req       (req),
    .run_en    (run_en),
    .rdy_sync  (rdy_sync),
    .osc_en    (osc_en),
    .gate_en   (gate_en),
    .wake_req  (wake_req)
);

// File: tb/osc_req_gater_test.sv
module osc_req_gater_test;
    localparam int  N      = 4;
    localparam int  SYNC   = 2;
    localparam time PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         stop_mode;
    logic [N-1:0] req, frame_done, wake_match, run_en;
    logic         osc_ready;
    logic         osc_en, wake_req;
    logic [N-1:0] gate_en;

    int checks   = 0;
    int failures = 0;

    always #(PERIOD/2) clk = ~clk;

    osc_req_gater #(.NUM_REQ(N), .SYNC_STAGES(SYNC)) uut (
        .clk(clk), .rst(rst), .stop_mode(stop_mode), .req(req),
        .frame_done(frame_done), .wake_match(wake_match), .run_en(run_en),
        .osc_ready(osc_ready), .osc_en(osc_en), .gate_en(gate_en),
        .wake_req(wake_req)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_out(string tag, logic o, logic [N-1:0] g, logic w);
        check({tag, " osc_en"},   32'(osc_en),   32'(o));
        check({tag, " gate_en"},  32'(gate_en),  32'(g));
        check({tag, " wake_req"}, 32'(wake_req), 32'(w));
    endtask

    // wait for ready through synchronizer: gate opens SYNC+1 edges after rise
    task automatic bring_ready(string tag, logic [N-1:0] waiting);
        osc_ready = 1'b1;
        for (int k = 0; k < SYNC; k++) begin
            tick();
            check_out({tag, " early gate R3"}, 1'b1, '0, 1'b0);
        end
        tick();
        check_out({tag, " gate open R3 R4"}, 1'b1, waiting, 1'b0);
    endtask

    task automatic pulse_done(int i, logic wm);
        frame_done[i] = 1'b1;
        wake_match[i] = wm;
        tick();
        frame_done = '0;
        wake_match = '0;
    endtask

    task automatic t_reset();
        rst = 1'b1; stop_mode = 1'b1; req = '0; frame_done = '0;
        wake_match = '0; run_en = '0; osc_ready = 1'b0;
        tick(); tick();
        check_out("R1 in reset", 1'b0, '0, 1'b0);
        rst = 1'b0;
        tick();
        check_out("R1 after reset", 1'b0, '0, 1'b0);
    endtask

    task automatic t_single_nonwake(int i);
        req[i] = 1'b1;
        tick();
        req[i] = 1'b0;
        check_out("R2 request latched", 1'b1, '0, 1'b0);
        tick();
        check_out("R2 request held after drop", 1'b1, '0, 1'b0);
        bring_ready("single", N'(1) << i);
        pulse_done(i, 1'b0);
        osc_ready = 1'b0;
        check_out("R5 non-wake frame ends", 1'b0, '0, 1'b0);
        tick(); tick(); tick();
        check_out("R5 stays stopped", 1'b0, '0, 1'b0);
    endtask

    task automatic t_wake(int i);
        req[i] = 1'b1;
        tick();
        req[i] = 1'b0;
        bring_ready("wake", N'(1) << i);
        pulse_done(i, 1'b1);
        check_out("R6 wake raised", 1'b1, N'(1) << i, 1'b1);
        tick(); tick();
        check_out("R6 wake held", 1'b1, N'(1) << i, 1'b1);
        stop_mode = 1'b0;
        run_en = 4'b1010;
        #1;
        check_out("R8 run mode passthru", 1'b0, 4'b1010, 1'b0);
        tick();
        stop_mode = 1'b1;
        osc_ready = 1'b0;
        #1;
        check_out("R9 re-entry idle", 1'b0, '0, 1'b0);
        tick();
        check_out("R9 stays idle", 1'b0, '0, 1'b0);
        tick(); tick();
    endtask

    task automatic t_multi();
        req = 4'b0101;
        tick();
        req = '0;
        bring_ready("multi", 4'b0101);
        pulse_done(0, 1'b0);
        check_out("R7 one left", 1'b1, 4'b0100, 1'b0);
        tick();
        check_out("R7 still on", 1'b1, 4'b0100, 1'b0);
        pulse_done(2, 1'b0);
        osc_ready = 1'b0;
        check_out("R7 all done", 1'b0, '0, 1'b0);
        tick(); tick();
    endtask

    task automatic t_early_done();
        req[1] = 1'b1;
        tick();
        req[1] = 1'b0;
        pulse_done(1, 1'b0);
        check_out("R10 early done ignored", 1'b1, '0, 1'b0);
        bring_ready("R10", 4'b0010);
        pulse_done(1, 1'b0);
        osc_ready = 1'b0;
        check_out("R10 finishes", 1'b0, '0, 1'b0);
        tick(); tick();
    endtask

    task automatic t_rearm();
        req[3] = 1'b1;
        tick();
        bring_ready("rearm", 4'b1000);
        pulse_done(3, 1'b0);
        check_out("R5 rearm waits", 1'b1, '0, 1'b0);
        req[3] = 1'b0;
        tick();
        check_out("R3 reopen after sync", 1'b1, 4'b1000, 1'b0);
        pulse_done(3, 1'b0);
        osc_ready = 1'b0;
        check_out("R5 rearm ends", 1'b0, '0, 1'b0);
        tick(); tick();
    endtask

    task automatic t_run_ignore();
        stop_mode = 1'b0;
        run_en = 4'b0110;
        req = 4'b1111;
        osc_ready = 1'b1;
        tick(); tick(); tick(); tick();
        check_out("R8 requests ignored", 1'b0, 4'b0110, 1'b0);
        frame_done = 4'b1111; wake_match = 4'b1111;
        tick();
        frame_done = '0; wake_match = '0;
        check_out("R8 frames ignored", 1'b0, 4'b0110, 1'b0);
        req = '0;
        osc_ready = 1'b0;
        stop_mode = 1'b1;
        tick();
        check_out("R9 stop entry clean", 1'b0, '0, 1'b0);
        tick(); tick();
    endtask

    initial begin
        t_reset();
        t_single_nonwake(0);
        t_single_nonwake(3);
        t_multi();
        t_early_done();
        t_rearm();
        t_wake(2);
        t_run_ignore();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule